// File: doc/BRIEF.md
# Execution Context Privilege Monitor

This block sits beside a CPU's memory bus and decides, cycle by cycle, what the running code may do. It keeps a context state with three values: firmware, application and syscall. Out of reset the system runs privileged firmware. When the CPU fetches its first instruction from outside the firmware ROM, the block moves to application mode. Only reset brings it back. Software has no register that can change the mode.

Every bus request is classed against a parameterised address map: firmware ROM, firmware RAM, the SPI master and a syscall window. Each request gets a verdict in the same cycle. The verdict covers four things:
- a trap pulse for a ROM fetch that is not allowed;
- a syscall interrupt pulse for a write into the syscall window;
- a deny line for application-mode access to the SPI master;
- a deny line for accesses below the stack floor of firmware RAM, which catches stack overflow.

A syscall taken from application mode opens a syscall context. Inside that context ROM code may run while `app_mode` stays high. An interrupt-return indication closes the context.

Top module: `exec_ctx_monitor`

## Requirements
- R1: After a synchronous reset `app_mode`, `trap`, `syscall_irq`, `spi_deny` and `stack_deny` are 0 and no syscall context is open.
- R2: An instruction fetch (`bus_valid`=1, `bus_instr`=1) from an address outside the ROM (0x00000000..0x00001FFF) sets `app_mode` to 1 from the next cycle. After that, no bus access of any kind clears it; only reset does.
- R3: In firmware mode, data accesses (`bus_instr`=0) leave `app_mode` at 0, wherever they are addressed.
- R4: A ROM fetch in application mode outside a syscall context drives `trap` high in the same cycle as the strobe. The pulse lasts only that cycle.
- R5: A ROM fetch in firmware mode raises no trap. A data read of ROM never raises a trap, in either mode.
- R6: A write to 0xE1000000..0xE1FFFFFF drives `syscall_irq` high in that same cycle. A read of the window does not, and neither does a write just outside it.
- R7: A syscall write in application mode opens the syscall context from the next cycle, and ROM fetches then raise no trap. `irq_return` closes the context from the next cycle, so a ROM fetch in the return cycle itself is still allowed. A syscall write in the same cycle as `irq_return` keeps the context open.
- R8: In application mode, including during a syscall, any access to the SPI master region 0xC3000000..0xC30000FF drives `spi_deny` in the same cycle. The line is never driven in firmware mode.
- R9: Any access to firmware RAM offsets below 0x200 (0xD0000000..0xD00001FF) drives `stack_deny` in the same cycle, in every mode. Offsets from 0x200 upward do not.
- R10: The reset-info area, the top 256 bytes of firmware RAM (0xD0000F00..0xD0000FFF), never drives `stack_deny`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request strobe, one cycle per request |
| bus_instr | input | 1 | Request is an instruction fetch |
| bus_write | input | 1 | Request is a write |
| bus_addr | input | 32 | Request byte address |
| irq_return | input | 1 | CPU is returning from an interrupt |
| app_mode | output | 1 | 1 in application mode (also during a syscall), 0 in firmware mode |
| trap | output | 1 | Forbidden ROM fetch, same cycle as the strobe |
| syscall_irq | output | 1 | Syscall interrupt request |
| spi_deny | output | 1 | SPI master access refused |
| stack_deny | output | 1 | Access below the firmware stack floor |

## Verification
The closing of a syscall context and a ROM fetch can fall in the same cycle. The bench drives `irq_return` together with a ROM fetch and expects no trap in that cycle. It then fetches from ROM again with no return and expects a trap, which pins the context end one cycle after the return. A second case drives a fresh syscall write in the same cycle as `irq_return` and checks that a later ROM fetch still runs without a trap.

// File: rtl/ecm_pkg.sv
package ecm_pkg;

    localparam int ADDR_W = 32;
    localparam int NREG   = 4;

    localparam int RG_ROM   = 0;
    localparam int RG_FWRAM = 1;
    localparam int RG_SPI   = 2;
    localparam int RG_SC    = 3;

    typedef enum logic [1:0] {
        CTX_FW      = 2'd0,
        CTX_APP     = 2'd1,
        CTX_SYSCALL = 2'd2
    } ctx_e;

    typedef struct packed {
        logic              valid;
        logic              instr;
        logic              write;
        logic [ADDR_W-1:0] addr;
    } bus_req_t;

    typedef struct packed {
        logic trap;
        logic syscall_irq;
        logic spi_deny;
        logic stack_deny;
    } verdict_t;

    function automatic logic is_fetch(input bus_req_t r);
        return r.valid && r.instr;
    endfunction

    function automatic logic is_data_write(input bus_req_t r);
        return r.valid && !r.instr && r.write;
    endfunction

endpackage

// File: rtl/ecm_region_match.sv
module ecm_region_match #(
    parameter logic [31:0] BASE = 32'h0,
    parameter int          AW   = 12
) (
    input  logic [31:0] addr,
    output logic        hit
);
    // Power-of-two window: compare only the bits above the window size.
    assign hit = (addr[31:AW] == BASE[31:AW]);
endmodule

// File: rtl/ecm_decode.sv
module ecm_decode
    import ecm_pkg::*;
#(
    parameter logic [31:0] ROM_BASE    = 32'h0000_0000,
    parameter int          ROM_AW      = 13,
    parameter logic [31:0] FWRAM_BASE  = 32'hD000_0000,
    parameter int          FWRAM_AW    = 12,
    parameter logic [31:0] SPI_BASE    = 32'hC300_0000,
    parameter int          SPI_AW      = 8,
    parameter logic [31:0] SC_BASE     = 32'hE100_0000,
    parameter int          SC_AW       = 24,
    parameter int          STACK_FLOOR = 512
) (
    input  bus_req_t          req,
    output logic [NREG-1:0]   hit,
    output logic              below_floor
);
    localparam logic [NREG*32-1:0] BASES = {SC_BASE, SPI_BASE, FWRAM_BASE, ROM_BASE};
    localparam int AWS [NREG] = '{ROM_AW, FWRAM_AW, SPI_AW, SC_AW};

    for (genvar i = 0; i < NREG; i++) begin : g_region
        ecm_region_match #(
            .BASE (BASES[i*32 +: 32]),
            .AW   (AWS[i])
        ) u_match (
            .addr (req.addr),
            .hit  (hit[i])
        );
    end

    logic [FWRAM_AW-1:0] ram_off;
    assign ram_off     = req.addr[FWRAM_AW-1:0];
    assign below_floor = (ram_off < FWRAM_AW'(STACK_FLOOR));
endmodule

// File: rtl/ecm_ctx_tracker.sv
module ecm_ctx_tracker
    import ecm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  bus_req_t        req,
    input  logic [NREG-1:0] hit,
    input  logic            irq_return,
    output ctx_e            ctx
);
    logic leave_rom;
    logic sc_write;
    ctx_e ctx_nxt;

    assign leave_rom = is_fetch(req) && !hit[RG_ROM];
    assign sc_write  = is_data_write(req) && hit[RG_SC];

    always_comb begin
        ctx_nxt = ctx;
        case (ctx)
            CTX_FW:      ctx_nxt = leave_rom ? CTX_APP : CTX_FW;
            CTX_APP:     ctx_nxt = sc_write ? CTX_SYSCALL : CTX_APP;
            CTX_SYSCALL: ctx_nxt = (irq_return && !sc_write) ? CTX_APP : CTX_SYSCALL;
            default:     ctx_nxt = CTX_APP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctx <= CTX_FW;
        else     ctx <= ctx_nxt;
    end
endmodule

// File: rtl/ecm_policy.sv
module ecm_policy
    import ecm_pkg::*;
(
    input  bus_req_t        req,
    input  logic [NREG-1:0] hit,
    input  logic            below_floor,
    input  ctx_e            ctx,
    output verdict_t        verdict
);
    logic in_app;
    logic may_run_rom;

    assign in_app      = (ctx != CTX_FW);
    assign may_run_rom = (ctx != CTX_APP);

    always_comb begin
        verdict             = '0;
        verdict.trap        = is_fetch(req) && hit[RG_ROM] && !may_run_rom;
        verdict.syscall_irq = is_data_write(req) && hit[RG_SC];
        verdict.spi_deny    = req.valid && hit[RG_SPI] && in_app;
        verdict.stack_deny  = req.valid && hit[RG_FWRAM] && below_floor;
    end
endmodule

// File: rtl/exec_ctx_monitor.sv
module exec_ctx_monitor
    import ecm_pkg::*;
#(
    parameter logic [31:0] ROM_BASE        = 32'h0000_0000,
    parameter int          ROM_AW          = 13,
    parameter logic [31:0] FWRAM_BASE      = 32'hD000_0000,
    parameter int          FWRAM_AW        = 12,
    parameter logic [31:0] SPI_BASE        = 32'hC300_0000,
    parameter int          SPI_AW          = 8,
    parameter logic [31:0] SC_BASE         = 32'hE100_0000,
    parameter int          SC_AW           = 24,
    parameter int          STACK_FLOOR     = 512,
    parameter int          RESETINFO_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_valid,
    input  logic        bus_instr,
    input  logic        bus_write,
    input  logic [31:0] bus_addr,
    input  logic        irq_return,
    output logic        app_mode,
    output logic        trap,
    output logic        syscall_irq,
    output logic        spi_deny,
    output logic        stack_deny
);
    localparam int FWRAM_BYTES = 1 << FWRAM_AW;
    localparam int FLOOR_LIMIT = FWRAM_BYTES - RESETINFO_BYTES;
    // The floor may never reach into the reset-info area.
    localparam int EFF_FLOOR   = (STACK_FLOOR > FLOOR_LIMIT) ? FLOOR_LIMIT : STACK_FLOOR;

    bus_req_t        req;
    logic [NREG-1:0] hit;
    logic            below_floor;
    ctx_e            ctx;
    verdict_t        verdict;

    assign req = '{valid: bus_valid, instr: bus_instr, write: bus_write, addr: bus_addr};

    ecm_decode #(
        .ROM_BASE    (ROM_BASE),
        .ROM_AW      (ROM_AW),
        .FWRAM_BASE  (FWRAM_BASE),
        .FWRAM_AW    (FWRAM_AW),
        .SPI_BASE    (SPI_BASE),
        .SPI_AW      (SPI_AW),
        .SC_BASE     (SC_BASE),
        .SC_AW       (SC_AW),
        .STACK_FLOOR (EFF_FLOOR)
    ) u_decode (
        .req         (req),
        .hit         (hit),
        .below_floor (below_floor)
    );

    ecm_ctx_tracker u_ctx (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .hit        (hit),
        .irq_return (irq_return),
        .ctx        (ctx)
    );

    ecm_policy u_policy (
        .req         (req),
        .hit         (hit),
        .below_floor (below_floor),
        .ctx         (ctx),
        .verdict     (verdict)
    );

    assign app_mode    = (ctx != CTX_FW);
    assign trap        = verdict.trap;
    assign syscall_irq = verdict.syscall_irq;
    assign spi_deny    = verdict.spi_deny;
    assign stack_deny  = verdict.stack_deny;
endmodule

// File: rtl/ecm_checker.sv
module ecm_checker #(
    parameter logic [31:0] ROM_BASE = 32'h0000_0000,
    parameter int          ROM_AW   = 13
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_valid,
    input logic        bus_instr,
    input logic        bus_write,
    input logic [31:0] bus_addr,
    input logic        irq_return,
    input logic        app_mode,
    input logic        trap,
    input logic        syscall_irq,
    input logic        spi_deny,
    input logic        stack_deny
);
    logic fetch_off_rom;
    assign fetch_off_rom = bus_valid && bus_instr && (bus_addr[31:ROM_AW] != ROM_BASE[31:ROM_AW]);

    p_reset_fw_r1: assert property (@(posedge clk) rst |=> !app_mode && !trap);

    p_enter_app_r2: assert property (@(posedge clk) disable iff (rst)
        fetch_off_rom |=> app_mode);

    p_app_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        app_mode |=> app_mode);

    p_data_keeps_fw_r3: assert property (@(posedge clk) disable iff (rst)
        (!app_mode && !(bus_valid && bus_instr)) |=> !app_mode);

    p_trap_on_fetch_r4: assert property (@(posedge clk) disable iff (rst)
        trap |-> (bus_valid && bus_instr && app_mode));

    p_no_trap_fw_r5: assert property (@(posedge clk) disable iff (rst)
        !app_mode |-> !trap);

    p_irq_on_write_r6: assert property (@(posedge clk) disable iff (rst)
        syscall_irq |-> (bus_valid && bus_write && !bus_instr));

    p_spi_deny_app_r8: assert property (@(posedge clk) disable iff (rst)
        spi_deny |-> (app_mode && bus_valid));

    p_stack_deny_valid_r9: assert property (@(posedge clk) disable iff (rst)
        stack_deny |-> bus_valid);
endmodule

bind exec_ctx_monitor ecm_checker #(
    .ROM_BASE (ROM_BASE),
    .ROM_AW   (ROM_AW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_valid   (bus_valid),
    .bus_instr   (bus_instr),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .irq_return  (irq_return),
    .app_mode    (app_mode),
    .trap        (trap),
    .syscall_irq (syscall_irq),
    .spi_deny    (spi_deny),
    .stack_deny  (stack_deny)
);

// File: tb/exec_ctx_monitor_test.sv
module exec_ctx_monitor_test;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic        bus_valid = 0;
    logic        bus_instr = 0;
    logic        bus_write = 0;
    logic [31:0] bus_addr = '0;
    logic        irq_return = 0;
    logic        app_mode, trap, syscall_irq, spi_deny, stack_deny;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_P/2) clk = ~clk;

    exec_ctx_monitor uut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_instr(bus_instr),
        .bus_write(bus_write), .bus_addr(bus_addr), .irq_return(irq_return),
        .app_mode(app_mode), .trap(trap), .syscall_irq(syscall_irq),
        .spi_deny(spi_deny), .stack_deny(stack_deny)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // Drive one request at the falling edge and let combinational outputs settle.
    task automatic put(input logic v, input logic i, input logic w,
                       input logic [31:0] a, input logic r);
        @(negedge clk);
        bus_valid = v; bus_instr = i; bus_write = w; bus_addr = a; irq_return = r;
        #1;
    endtask

    task automatic idle();
        put(0, 0, 0, 32'h0, 0);
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (2) idle();
        rst = 0;
        idle();
        chk("R1 app_mode", app_mode, 0);
        chk("R1 trap", trap, 0);
        chk("R1 syscall_irq", syscall_irq, 0);
        chk("R1 spi_deny", spi_deny, 0);
        chk("R1 stack_deny", stack_deny, 0);
    endtask

    task automatic t_firmware();
        put(1, 1, 0, 32'h0000_0100, 0);
        chk("R5 rom fetch in fw", trap, 0);
        put(1, 0, 0, 32'hD000_0400, 0);
        put(1, 0, 1, 32'h4000_0000, 0);
        idle();
        chk("R3 data keeps fw", app_mode, 0);
        put(1, 0, 0, 32'hC300_0010, 0);
        chk("R8 spi in fw", spi_deny, 0);
        put(1, 0, 1, 32'hD000_0010, 0);
        chk("R9 below floor fw", stack_deny, 1);
        put(1, 0, 0, 32'hD000_01FC, 0);
        chk("R9 last below floor", stack_deny, 1);
        put(1, 0, 0, 32'hD000_0200, 0);
        chk("R9 at floor", stack_deny, 0);
        put(1, 0, 1, 32'hD000_0F80, 0);
        chk("R10 reset-info fw", stack_deny, 0);
        put(1, 0, 1, 32'hE100_0040, 0);
        chk("R6 syscall write fw", syscall_irq, 1);
        idle();
        chk("R3 syscall write keeps fw", app_mode, 0);
        put(1, 1, 0, 32'h0000_0200, 0);
        chk("R5 rom fetch fw after sc", trap, 0);
    endtask

    task automatic t_enter_app();
        put(1, 1, 0, 32'h4000_0000, 0);
        chk("R2 mode before edge", app_mode, 0);
        idle();
        chk("R2 app entered", app_mode, 1);
        put(1, 1, 0, 32'h0000_0080, 0);
        chk("R4 rom fetch traps", trap, 1);
        idle();
        chk("R4 trap single cycle", trap, 0);
        put(1, 0, 0, 32'h0000_0080, 0);
        chk("R5 rom data read app", trap, 0);
        put(1, 0, 0, 32'hC300_00FC, 0);
        chk("R8 spi in app", spi_deny, 1);
        put(1, 0, 0, 32'hC300_0100, 0);
        chk("R8 past spi region", spi_deny, 0);
        put(1, 0, 1, 32'hD000_0004, 0);
        chk("R9 below floor app", stack_deny, 1);
        put(1, 0, 0, 32'hD000_0FFC, 0);
        chk("R10 reset-info app", stack_deny, 0);
        put(1, 0, 0, 32'hE100_0000, 0);
        chk("R6 window read", syscall_irq, 0);
        put(1, 0, 1, 32'hE200_0000, 0);
        chk("R6 write above window", syscall_irq, 0);
        put(1, 0, 1, 32'hE0FF_FFFC, 0);
        chk("R6 write below window", syscall_irq, 0);
    endtask

    task automatic t_syscall();
        put(1, 0, 1, 32'hE1FF_FFFC, 0);
        chk("R6 syscall write app", syscall_irq, 1);
        put(1, 1, 0, 32'h0000_0010, 0);
        chk("R7 rom fetch in syscall", trap, 0);
        chk("R7 app_mode in syscall", app_mode, 1);
        put(1, 0, 0, 32'hC300_0000, 0);
        chk("R8 spi in syscall", spi_deny, 1);
        put(1, 1, 0, 32'h0000_0020, 1);
        chk("R7 fetch in return cycle", trap, 0);
        put(1, 1, 0, 32'h0000_0024, 0);
        chk("R7 trap after return", trap, 1);
        // re-entry in the same cycle as a return keeps the context
        put(1, 0, 1, 32'hE100_0000, 0);
        put(1, 0, 1, 32'hE100_0000, 1);
        put(1, 1, 0, 32'h0000_0030, 0);
        chk("R7 set wins over return", trap, 0);
        put(0, 0, 0, 32'h0, 1);
        put(1, 1, 0, 32'h0000_0034, 0);
        chk("R7 closed after return", trap, 1);
    endtask

    task automatic t_sticky();
        put(1, 0, 1, 32'h0000_0000, 0);
        put(1, 0, 1, 32'hD000_0800, 0);
        put(1, 1, 0, 32'h0000_0000, 0);
        idle();
        chk("R2 app sticky", app_mode, 1);
        rst = 1;
        idle();
        rst = 0;
        idle();
        chk("R1 reset clears app", app_mode, 0);
        put(1, 1, 0, 32'h0000_0000, 0);
        chk("R1 no context after reset", trap, 0);
    endtask

    initial begin
        t_reset();
        t_firmware();
        t_enter_app();
        t_syscall();
        t_sticky();
        idle();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements): got hang expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule